// File: doc/BRIEF.md
# Windowed Pixel Array Readout Sequencer

This block reads a rectangular window out of a 1024 by 1024 pixel array at display line rate. A position converter supplies the window origin as a 10-bit start row and a 10-bit start column. The block takes that origin only when a frame begins, so the window cannot move part way through a frame. It also produces the row and column addresses for each display line, along with one-cycle enable strobes that tell the array when a new row and a new pixel start.

Both external drive inputs are synchronised through two flip-flops, and the block acts on their rising edges. A rising edge of the vertical drive starts a frame. A rising edge of the horizontal drive starts a line. Every sensor row appears on two consecutive display lines. This fills a taller display area from a window only 100 rows high. Each pixel lasts eight master clocks, and the rest of the line stays idle. A free-running divide-by-four output clocks an external sync generator.

Top module: `win_readout_seq`

## Requirements
- R1: `sync_clk_o` is the master clock divided by four. It is low for the first two clock edges after reset release and then high for the next two, and this pattern repeats.
- R2: A rising edge on `hd_i` or `vd_i` takes effect through a two-flop synchroniser. When `hd_i` goes high between two clock edges, `row_en_o` is high after the third of the following edges.
- R3: The start row and start column are captured only on a frame start. When `start_row_i` or `start_col_i` changes mid-frame, the addresses of that frame do not change.
- R4: Line k of a frame (k counted from 0) puts `start_row + floor(k/LINE_REP)` on `row_addr_o`, where LINE_REP defaults to 2. `row_addr_o` changes only in the cycle where `row_en_o` is high.
- R5: A frame has at most WIN_ROWS*LINE_REP lines (200 by default). Horizontal edges that arrive after those lines and before the next frame start produce no strobe and no address change.
- R6: Each line starts at the captured start column. The column address goes up by one every PIX_CLKS clocks (default 8) for WIN_COLS pixels (default 100). After the last pixel it holds its value.
- R7: `col_en_o` is high for one clock at the start of every pixel. `row_en_o` is high for one clock at the start of every line, in the same cycle as that line's first `col_en_o`.
- R8: Row and column addresses wrap modulo 1024, so 1023 is followed by 0.
- R9: After reset both addresses are 0 and both strobes are low. Horizontal edges that arrive before the first frame start are ignored.
- R10: If a frame start and a line start arrive in the same cycle, the frame start wins and no line begins. A frame start during a line ends that line at once, and no further pixel strobes follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, 16 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Horizontal drive (line start), asynchronous |
| vd_i | input | 1 | Vertical drive (frame start), asynchronous |
| start_row_i | input | 10 | Window origin row from the position converter |
| start_col_i | input | 10 | Window origin column from the position converter |
| sync_clk_o | output | 1 | Master clock divided by four, for the sync generator |
| row_addr_o | output | 10 | Absolute row address |
| col_addr_o | output | 10 | Absolute column address |
| row_en_o | output | 1 | One-cycle strobe at each line start |
| col_en_o | output | 1 | One-cycle strobe at each pixel start |

## Verification
The bench builds the block with a window of 12 columns by 5 rows, 4 clocks per pixel and the default repeat of 2. Address widths stay at their defaults. With these values a whole frame takes only a few hundred cycles. The bench can therefore run past the last line of a frame, start a second frame from an origin near 1023 so that both address counters wrap, and test frame starts that meet or cut into a line, all in one short run. The 10-bit address width is kept so that wrapping is tested at the real array size.

// File: rtl/win_seq_pkg.sv
package win_seq_pkg;
  localparam int unsigned ADDR_W_DEF    = 10;
  localparam int unsigned WIN_COLS_DEF  = 100;
  localparam int unsigned WIN_ROWS_DEF  = 100;
  localparam int unsigned LINE_REP_DEF  = 2;
  localparam int unsigned PIX_CLKS_DEF  = 8;
  localparam int unsigned SYNC_DIV_DEF  = 4;
endpackage

// File: rtl/win_edge_sync.sv
module win_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  assert_single_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/win_clk_div.sv
module win_clk_div #(
  parameter int unsigned DIV = win_seq_pkg::SYNC_DIV_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o
);
  localparam int unsigned DW = ($clog2(DIV) > 0) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign div_o = div_q[DW-1];

  assert_sync_half_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o != $past(div_o)) |=> $stable(div_o));
endmodule

// File: rtl/win_line_ctrl.sv
module win_line_ctrl #(
  parameter int unsigned ADDR_W   = win_seq_pkg::ADDR_W_DEF,
  parameter int unsigned WIN_ROWS = win_seq_pkg::WIN_ROWS_DEF,
  parameter int unsigned LINE_REP = win_seq_pkg::LINE_REP_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hd_rise_i,
  input  logic              vd_rise_i,
  input  logic [ADDR_W-1:0] start_row_i,
  input  logic [ADDR_W-1:0] start_col_i,
  output logic              line_go_o,
  output logic [ADDR_W-1:0] start_col_o,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic              row_en_o
);
  localparam int unsigned LINES = WIN_ROWS * LINE_REP;
  localparam int unsigned LW    = $clog2(LINES + 1);
  localparam int unsigned RW    = $clog2(WIN_ROWS + 1);
  localparam int unsigned PW    = ($clog2(LINE_REP) > 0) ? $clog2(LINE_REP) : 1;

  logic              frame_act_q;
  logic [ADDR_W-1:0] start_row_q, start_col_q;
  logic [LW-1:0]     line_idx_q;
  logic [RW-1:0]     win_row_q;
  logic [PW-1:0]     rep_q;

  assign line_go_o   = hd_rise_i & ~vd_rise_i & frame_act_q & (line_idx_q < LW'(LINES));
  assign start_col_o = start_col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_act_q <= 1'b0;
      start_row_q <= '0;
      start_col_q <= '0;
      line_idx_q  <= '0;
      win_row_q   <= '0;
      rep_q       <= '0;
      row_addr_o  <= '0;
      row_en_o    <= 1'b0;
    end else begin
      row_en_o <= 1'b0;
      if (vd_rise_i) begin
        frame_act_q <= 1'b1;
        start_row_q <= start_row_i;
        start_col_q <= start_col_i;
        line_idx_q  <= '0;
      end else if (line_go_o) begin
        row_en_o   <= 1'b1;
        line_idx_q <= line_idx_q + 1'b1;
        if (line_idx_q == '0) begin
          row_addr_o <= start_row_q;
          win_row_q  <= '0;
          rep_q      <= '0;
        end else if (rep_q == PW'(LINE_REP - 1)) begin
          rep_q      <= '0;
          win_row_q  <= win_row_q + 1'b1;
          row_addr_o <= row_addr_o + 1'b1;  // wraps at array edge
        end else begin
          rep_q <= rep_q + 1'b1;
        end
      end
    end
  end

  assert_line_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_idx_q <= LW'(LINES)) && (win_row_q < RW'(WIN_ROWS)));
  assert_row_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_en_o |-> $stable(row_addr_o));
  assert_row_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_en_o |=> !row_en_o);
  assert_origin_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd_rise_i |=> $stable(start_col_q) && $stable(start_row_q));
endmodule

// File: rtl/win_pixel_ctrl.sv
module win_pixel_ctrl #(
  parameter int unsigned ADDR_W   = win_seq_pkg::ADDR_W_DEF,
  parameter int unsigned WIN_COLS = win_seq_pkg::WIN_COLS_DEF,
  parameter int unsigned PIX_CLKS = win_seq_pkg::PIX_CLKS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_go_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] start_col_i,
  output logic [ADDR_W-1:0] col_addr_o,
  output logic              col_en_o
);
  localparam int unsigned CW = ($clog2(WIN_COLS) > 0) ? $clog2(WIN_COLS) : 1;
  localparam int unsigned SW = ($clog2(PIX_CLKS) > 0) ? $clog2(PIX_CLKS) : 1;

  logic          busy_q;
  logic [CW-1:0] pix_q;
  logic [SW-1:0] sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      pix_q      <= '0;
      sub_q      <= '0;
      col_addr_o <= '0;
      col_en_o   <= 1'b0;
    end else begin
      col_en_o <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (line_go_i) begin
        busy_q     <= 1'b1;
        pix_q      <= '0;
        sub_q      <= '0;
        col_addr_o <= start_col_i;
        col_en_o   <= 1'b1;
      end else if (busy_q) begin
        if (sub_q == SW'(PIX_CLKS - 1)) begin
          sub_q <= '0;
          if (pix_q == CW'(WIN_COLS - 1)) begin
            busy_q <= 1'b0;
          end else begin
            pix_q      <= pix_q + 1'b1;
            col_addr_o <= col_addr_o + 1'b1;  // wraps at array edge
            col_en_o   <= 1'b1;
          end
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assert_col_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_go_i |=> (col_addr_o == $past(col_addr_o)) || (col_addr_o == $past(col_addr_o) + 1'b1));
  assert_col_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_en_o |=> !col_en_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !col_en_o);
endmodule

// File: rtl/win_readout_seq.sv
module win_readout_seq #(
  parameter int unsigned ADDR_W   = win_seq_pkg::ADDR_W_DEF,
  parameter int unsigned WIN_COLS = win_seq_pkg::WIN_COLS_DEF,
  parameter int unsigned WIN_ROWS = win_seq_pkg::WIN_ROWS_DEF,
  parameter int unsigned LINE_REP = win_seq_pkg::LINE_REP_DEF,
  parameter int unsigned PIX_CLKS = win_seq_pkg::PIX_CLKS_DEF,
  parameter int unsigned SYNC_DIV = win_seq_pkg::SYNC_DIV_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hd_i,
  input  logic              vd_i,
  input  logic [ADDR_W-1:0] start_row_i,
  input  logic [ADDR_W-1:0] start_col_i,
  output logic              sync_clk_o,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic [ADDR_W-1:0] col_addr_o,
  output logic              row_en_o,
  output logic              col_en_o
);
  logic              hd_rise, vd_rise, line_go;
  logic [ADDR_W-1:0] start_col;

  win_edge_sync u_hd_sync (.clk_i, .rst_ni, .d_i(hd_i), .rise_o(hd_rise));
  win_edge_sync u_vd_sync (.clk_i, .rst_ni, .d_i(vd_i), .rise_o(vd_rise));

  win_clk_div #(.DIV(SYNC_DIV)) u_div (.clk_i, .rst_ni, .div_o(sync_clk_o));

  win_line_ctrl #(
    .ADDR_W(ADDR_W), .WIN_ROWS(WIN_ROWS), .LINE_REP(LINE_REP)
  ) u_line (
    .clk_i, .rst_ni,
    .hd_rise_i(hd_rise), .vd_rise_i(vd_rise),
    .start_row_i, .start_col_i,
    .line_go_o(line_go), .start_col_o(start_col),
    .row_addr_o, .row_en_o
  );

  win_pixel_ctrl #(
    .ADDR_W(ADDR_W), .WIN_COLS(WIN_COLS), .PIX_CLKS(PIX_CLKS)
  ) u_pix (
    .clk_i, .rst_ni,
    .line_go_i(line_go), .abort_i(vd_rise),
    .start_col_i(start_col),
    .col_addr_o, .col_en_o
  );

  assert_strobe_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_en_o |-> col_en_o);
endmodule

// File: tb/win_readout_seq_test.sv
`timescale 1ns/1ps
module win_readout_seq_test;
  localparam int AW = 10, COLS = 12, ROWS = 5, REP = 2, PIX = 4;
  localparam int LINES = ROWS * REP;
  localparam int AMOD = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, hd = 1'b0, vd = 1'b0;
  logic [AW-1:0] srow = '0, scol = '0;
  logic sync_clk, row_en, col_en;
  logic [AW-1:0] row_addr, col_addr;

  always #2 clk = ~clk;

  win_readout_seq #(.ADDR_W(AW), .WIN_COLS(COLS), .WIN_ROWS(ROWS),
                    .LINE_REP(REP), .PIX_CLKS(PIX), .SYNC_DIV(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hd_i(hd), .vd_i(vd),
    .start_row_i(srow), .start_col_i(scol),
    .sync_clk_o(sync_clk), .row_addr_o(row_addr), .col_addr_o(col_addr),
    .row_en_o(row_en), .col_en_o(col_en));

  int n_run = 0, n_fail = 0;
  string tag = "R9";
  bit done = 1'b0;

  task automatic chk(string t, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
    end
  endtask

  // behavioural reference, stepped on each rising edge
  int h1, h2, h3, v1, v2, v3, k;
  int frame_on, lines, st_row, st_col, line_on, pix, phase;
  int e_row, e_col, e_ren, e_cen;
  int ren_count;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; v1 = 0; v2 = 0; v3 = 0; k = 0;
      frame_on = 0; lines = 0; st_row = 0; st_col = 0; line_on = 0;
      pix = 0; phase = 0; e_row = 0; e_col = 0; e_ren = 0; e_cen = 0;
    end else begin
      automatic int hr = h2 && !h3;
      automatic int vr = v2 && !v3;
      h3 = h2; h2 = h1; h1 = hd;
      v3 = v2; v2 = v1; v1 = vd;
      k++;
      e_ren = 0; e_cen = 0;
      if (vr) begin
        frame_on = 1; lines = 0; st_row = srow; st_col = scol; line_on = 0;
      end else if (hr && frame_on && lines < LINES) begin
        e_row = (st_row + lines / REP) % AMOD;
        lines++;
        e_ren = 1; e_cen = 1; line_on = 1; pix = 0; phase = 0; e_col = st_col;
      end else if (line_on) begin
        phase++;
        if (phase == PIX) begin
          phase = 0;
          if (pix == COLS - 1) line_on = 0;
          else begin
            pix++; e_col = (e_col + 1) % AMOD; e_cen = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({tag, "/R1"}, "sync_clk", int'(sync_clk), int'((k % 4) >= 2));
      chk({tag, "/R4"}, "row_addr", int'(row_addr), e_row);
      chk({tag, "/R6"}, "col_addr", int'(col_addr), e_col);
      chk({tag, "/R7"}, "row_en", int'(row_en), e_ren);
      chk({tag, "/R7"}, "col_en", int'(col_en), e_cen);
      if (row_en) ren_count++;
    end
  end

  task automatic pulse_hd(int gap);
    hd = 1'b1; repeat (3) @(negedge clk);
    hd = 1'b0; repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_vd(int gap);
    vd = 1'b1; repeat (3) @(negedge clk);
    vd = 1'b0; repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9", "reset row_addr", int'(row_addr), 0);
    chk("R9", "reset col_addr", int'(col_addr), 0);
    chk("R9", "reset strobes", int'(row_en) + int'(col_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tag = "R9";
    ren_count = 0;
    pulse_hd(40);
    pulse_hd(40);
    chk("R9", "strobes before first frame", ren_count, 0);

    // frame 1, origin 5/20
    srow = 10'd5; scol = 10'd20;
    tag = "R2";
    pulse_vd(8);
    ren_count = 0;
    begin
      int n = 0;
      hd = 1'b1;
      for (int i = 1; i <= 6; i++) begin
        @(negedge clk);
        if (row_en && n == 0) n = i;
        if (i == 3) hd = 1'b0;
      end
      chk("R2", "edges to row_en", n, 3);
      repeat (60) @(negedge clk);
    end
    tag = "R4";
    for (int i = 1; i < LINES; i++) begin
      if (i == 4) begin
        tag = "R3";
        srow = 10'd1023; scol = 10'd1018;
      end
      pulse_hd(61);
    end
    chk("R4", "row after last line", int'(row_addr), 5 + (LINES - 1) / REP);
    tag = "R5";
    pulse_hd(61);
    pulse_hd(61);
    chk("R5", "lines in frame", ren_count, LINES);
    chk("R3", "col held at old origin end", int'(col_addr), 20 + COLS - 1);

    // frame 2, origin 1023/1018: wrap
    tag = "R8";
    pulse_vd(8);
    for (int i = 0; i < 4; i++) pulse_hd(61);
    chk("R8", "col wrapped at line end", int'(col_addr), (1018 + COLS - 1) % AMOD);
    chk("R8", "row wrapped", int'(row_addr), 0);

    // R10: simultaneous and mid-line frame start
    tag = "R10";
    ren_count = 0;
    hd = 1'b1; vd = 1'b1;
    repeat (3) @(negedge clk);
    hd = 1'b0; vd = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10", "line on simultaneous edges", ren_count, 0);
    pulse_hd(10);
    pulse_vd(30);
    chk("R10", "col after abort", int'(col_addr), 1018 + 3);
    pulse_hd(61);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule